// File: doc/BRIEF.md
# Three-Row Sliding Decode Window Controller

This block sits between a line store of coded samples and a pixel decision/reconstruction datapath. Coded samples arrive one per beat in raster order. The block keeps three rows of them in a circular row store. As soon as the three rows of a band are complete, it presents a 3x3 neighbourhood to the decoder on every clock. Each new neighbourhood sits two columns to the right of the previous one. The rightmost column of the previous neighbourhood is kept in a register and becomes the left column of the next one.

When a band is finished, the band origin moves down two rows. The bottom row of the finished band becomes the top row of the next band. At the right and bottom image edges, the missing column or row is filled by repeating the last real one. The decoder returns four pixels per clock. The block passes each group of four into a fast clock domain, running at four times the rate, through two alternating holding registers. The fast side emits one pixel per fast clock.

Top module: `decode_window_ctrl`

## Requirements
- R1: No window is issued before the first three rows of a frame (3*IMG_W samples) have been accepted. The first window is valid on the clock edge after the edge that accepts the last sample of row 2.
- R2: Band b covers image rows 2b, 2b+1 and 2b+2, for b from 0 to IMG_H/2-1. Within a band, the IMG_W/2 windows come on consecutive cycles. Window n of a band covers columns 2n, 2n+1 and 2n+2.
- R3: in_ready_o is low whenever the next row to be written would overwrite a row the current band still uses, that is, when rows received >= band top row + 3. It is also low once all IMG_H rows of the frame have arrived. It rises again on the same edge that issues the last window of the blocking band.
- R4: In win_o, element 3*i+j occupies bits [SW*(3*i+j) +: SW], where i is the row offset and j is the column offset. A column index of IMG_W or more is replaced by IMG_W-1, and a row index of IMG_H or more is replaced by IMG_H-1.
- R5: frame_done_o is high for exactly one cycle, in the same cycle as the last window of a frame. After that, the next frame is accepted starting from row 0.
- R6: Each decoded group on dec_pix_i is sent out lane 0 first, where lane k is bits [PW*k +: PW], at one pixel per fast clock while pix_valid_o is high. Groups leave in the order they arrived.
- R7: If groups arrive on consecutive cycles, the serial stream has no gap and underflow_o stays low. If a group is late in the middle of a band, underflow_o pulses. After the last group of a band, a gap raises no underflow.
- R8: After reset, in_ready_o is high, and win_valid_o, frame_done_o, pix_valid_o and underflow_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Window-side clock |
| fast_clk_i | input | 1 | Serial output clock, four times clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| in_valid_i | input | 1 | Coded sample valid |
| in_sample_i | input | SW | Coded sample, in raster order |
| in_ready_o | output | 1 | Row store can take a sample |
| win_valid_o | output | 1 | Window valid for the decoder |
| win_o | output | 9*SW | 3x3 neighbourhood, laid out as in R4 |
| frame_done_o | output | 1 | Pulse with the last window of a frame |
| dec_valid_i | input | 1 | Decoded group valid |
| dec_pix_i | input | 4*PW | Four decoded pixels, lane 0 first |
| pix_valid_o | output | 1 | Serial pixel valid (fast domain) |
| pix_o | output | PW | Serial pixel (fast domain) |
| underflow_o | output | 1 | Pulse: stream gap inside a band (fast domain) |

## Verification
Two events can share one edge. The window scanner issues the last window of a band on the same edge where the row store reopens its input. The bench holds input idle after row 2 and checks that in_ready_o stays low through band 0 and goes high exactly with the eighth window. In the fast domain, a group arrival can land on the same fast cycle as the end of the previous group. The bench runs one frame with back-to-back groups, where any missed coincidence would show as an underflow or a gap in the pixel log. It then delays one group in the middle of a band and expects exactly one underflow pulse, with every pixel still in order.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
package dwc_pkg;
  localparam int unsigned WIN_N = 9;
  localparam int unsigned GRP_N = 4;
  typedef logic [1:0] slot_t;

  function automatic slot_t slot_inc(slot_t s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction
endpackage

// File: rtl/dwc_line_buf.sv
`timescale 1ns/1ps
module dwc_line_buf
  import dwc_pkg::*;
#(
  parameter int unsigned SW    = 8,
  parameter int unsigned IMG_W = 16,
  parameter int unsigned IMG_H = 8,
  localparam int unsigned CW = $clog2(IMG_W),
  localparam int unsigned RW = $clog2(IMG_H + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [SW-1:0]         in_sample_i,
  output logic                  in_ready_o,
  input  logic [RW-1:0]         band_top_i,
  input  logic                  frame_end_i,
  output logic [RW-1:0]         rows_rcv_o,
  input  slot_t [2:0]           rd_slot_i,
  input  logic [2:0][CW-1:0]    rd_col_i,
  output logic [8:0][SW-1:0]    rd_data_o
);
  logic [SW-1:0] mem_q [3][IMG_W];
  logic [CW-1:0] wr_col_q;
  logic [RW-1:0] rows_q;
  slot_t         wslot_q;
  logic          wr_en;

  // a row may land only where no row of the current band lives
  assign in_ready_o = (32'(rows_q) < IMG_H) &&
                      (32'(rows_q) < 32'(band_top_i) + 32'd3);
  assign wr_en      = in_valid_i && in_ready_o;
  assign rows_rcv_o = rows_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wslot_q][wr_col_q] <= in_sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_col_q <= '0;
      rows_q   <= '0;
      wslot_q  <= 2'd0;
    end else if (frame_end_i) begin
      wr_col_q <= '0;
      rows_q   <= '0;
      wslot_q  <= 2'd0;
    end else if (wr_en) begin
      if (wr_col_q == CW'(IMG_W - 1)) begin
        wr_col_q <= '0;
        rows_q   <= rows_q + RW'(1);
        wslot_q  <= slot_inc(wslot_q);
      end else begin
        wr_col_q <= wr_col_q + CW'(1);
      end
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_row
    for (genvar j = 0; j < 3; j++) begin : g_col
      assign rd_data_o[3*i+j] = mem_q[rd_slot_i[i]][rd_col_i[j]];
    end
  end

  a_r3_row_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rows_q) <= 32'(band_top_i) + 32'd3);
  a_r5_clear_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (rows_q == '0));
endmodule

// File: rtl/dwc_scan.sv
`timescale 1ns/1ps
module dwc_scan
  import dwc_pkg::*;
#(
  parameter int unsigned SW    = 8,
  parameter int unsigned IMG_W = 16,
  parameter int unsigned IMG_H = 8,
  localparam int unsigned CW = $clog2(IMG_W),
  localparam int unsigned RW = $clog2(IMG_H + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [RW-1:0]         rows_rcv_i,
  output logic [RW-1:0]         band_top_o,
  output logic                  frame_end_o,
  output slot_t [2:0]           rd_slot_o,
  output logic [2:0][CW-1:0]    rd_col_o,
  input  logic [8:0][SW-1:0]    rd_data_i,
  output logic                  win_valid_o,
  output logic [8:0][SW-1:0]    win_o,
  output logic                  frame_done_o
);
  logic [CW-1:0]         col_q;
  logic [RW-1:0]         top_q;
  slot_t                 stop_q;
  logic [2:0][SW-1:0]    saved_q;
  logic [8:0][SW-1:0]    win_c;
  logic [8:0][SW-1:0]    win_q;
  logic                  win_valid_q, done_q;
  int unsigned           need;
  logic                  go, last_col, last_band;
  slot_t                 s1, s2;

  assign need      = (32'(top_q) + 32'd3 > IMG_H) ? IMG_H : 32'(top_q) + 32'd3;
  assign go        = 32'(rows_rcv_i) >= need;
  assign last_col  = (col_q == CW'(IMG_W - 2));
  assign last_band = (32'(top_q) == IMG_H - 2);

  assign s1 = slot_inc(stop_q);
  assign s2 = (32'(top_q) + 32'd2 < IMG_H) ? slot_inc(s1) : s1;
  assign rd_slot_o = {s2, s1, stop_q};

  assign rd_col_o[0] = col_q;
  assign rd_col_o[1] = col_q + CW'(1);
  assign rd_col_o[2] = (32'(col_q) + 32'd2 >= IMG_W) ? CW'(IMG_W - 1) : col_q + CW'(2);

  // left column comes from the saved right column except at band start
  for (genvar i = 0; i < 3; i++) begin : g_win
    assign win_c[3*i]   = (col_q == '0) ? rd_data_i[3*i] : saved_q[i];
    assign win_c[3*i+1] = rd_data_i[3*i+1];
    assign win_c[3*i+2] = rd_data_i[3*i+2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q       <= '0;
      top_q       <= '0;
      stop_q      <= 2'd0;
      saved_q     <= '0;
      win_q       <= '0;
      win_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      win_valid_q <= go;
      done_q      <= go && last_col && last_band;
      if (go) begin
        win_q <= win_c;
        for (int i = 0; i < 3; i++) saved_q[i] <= rd_data_i[3*i+2];
        if (last_col) begin
          col_q <= '0;
          if (last_band) begin
            top_q  <= '0;
            stop_q <= 2'd0;
          end else begin
            top_q  <= top_q + RW'(2);
            stop_q <= slot_inc(s1);
          end
        end else begin
          col_q <= col_q + CW'(2);
        end
      end
    end
  end

  assign band_top_o   = top_q;
  assign frame_end_o  = go && last_col && last_band;
  assign win_valid_o  = win_valid_q;
  assign win_o        = win_q;
  assign frame_done_o = done_q;

  a_r2_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && $past(go) && col_q != '0) |-> (col_q == $past(col_q) + CW'(2)));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: rtl/dwc_serializer.sv
`timescale 1ns/1ps
module dwc_serializer
  import dwc_pkg::*;
#(
  parameter int unsigned PW  = 8,
  parameter int unsigned GPB = 8,
  localparam int unsigned GW = (GPB > 1) ? $clog2(GPB) : 1
) (
  input  logic                      clk_i,
  input  logic                      fast_clk_i,
  input  logic                      rst_ni,
  input  logic                      dec_valid_i,
  input  logic [GRP_N-1:0][PW-1:0]  dec_pix_i,
  output logic                      pix_valid_o,
  output logic [PW-1:0]             pix_o,
  output logic                      underflow_o
);
  // slow side: alternate holding registers, one toggle per write
  logic [1:0][GRP_N-1:0][PW-1:0] hold_q;
  logic [1:0]                    last_q;
  logic                          wsel_q, tog_q;
  logic [GW-1:0]                 grp_q;
  logic                          grp_last;

  assign grp_last = (32'(grp_q) == GPB - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      last_q <= '0;
      wsel_q <= 1'b0;
      tog_q  <= 1'b0;
      grp_q  <= '0;
    end else if (dec_valid_i) begin
      hold_q[wsel_q] <= dec_pix_i;
      last_q[wsel_q] <= grp_last;
      wsel_q         <= ~wsel_q;
      tog_q          <= ~tog_q;
      grp_q          <= grp_last ? '0 : grp_q + GW'(1);
    end
  end

  // fast side
  logic [1:0] sync_q;
  logic       seen_q, busy_q, rsel_q, nxt_q, under_q;
  logic [1:0] pend_q, phase_q;
  logic       edge_c, avail_c, grp_end_c, take_c, under_c;

  assign edge_c    = sync_q[1] ^ seen_q;
  assign avail_c   = (pend_q != 2'd0) || edge_c;
  assign grp_end_c = busy_q && (phase_q == 2'd3);
  assign take_c    = (!busy_q || grp_end_c) && avail_c;
  assign under_c   = grp_end_c && !avail_c && !last_q[rsel_q];

  always_ff @(posedge fast_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      seen_q  <= 1'b0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      phase_q <= '0;
      rsel_q  <= 1'b0;
      nxt_q   <= 1'b0;
      under_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], tog_q};
      seen_q  <= sync_q[1];
      pend_q  <= pend_q + {1'b0, edge_c} - {1'b0, take_c};
      under_q <= under_c;
      if (take_c) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
        rsel_q  <= nxt_q;
        nxt_q   <= ~nxt_q;
      end else if (grp_end_c) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  assign pix_valid_o = busy_q;
  assign pix_o       = hold_q[rsel_q][phase_q];
  assign underflow_o = under_q;

  a_r7_pend_max: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    pend_q != 2'd3);
  a_r6_lane_step: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    (busy_q && phase_q != 2'd3) |=> (busy_q && phase_q == $past(phase_q) + 2'd1));
endmodule

// File: rtl/decode_window_ctrl.sv
`timescale 1ns/1ps
module decode_window_ctrl
  import dwc_pkg::*;
#(
  parameter int unsigned SW    = 8,
  parameter int unsigned PW    = 8,
  parameter int unsigned IMG_W = 16,
  parameter int unsigned IMG_H = 8,
  localparam int unsigned CW = $clog2(IMG_W),
  localparam int unsigned RW = $clog2(IMG_H + 1)
) (
  input  logic                  clk_i,
  input  logic                  fast_clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [SW-1:0]         in_sample_i,
  output logic                  in_ready_o,
  output logic                  win_valid_o,
  output logic [WIN_N*SW-1:0]   win_o,
  output logic                  frame_done_o,
  input  logic                  dec_valid_i,
  input  logic [GRP_N*PW-1:0]   dec_pix_i,
  output logic                  pix_valid_o,
  output logic [PW-1:0]         pix_o,
  output logic                  underflow_o
);
  logic [RW-1:0]          rows_rcv, band_top;
  logic                   frame_end;
  slot_t [2:0]            rd_slot;
  logic [2:0][CW-1:0]     rd_col;
  logic [8:0][SW-1:0]     rd_data, win;

  dwc_line_buf #(.SW(SW), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_buf (
    .clk_i, .rst_ni, .in_valid_i, .in_sample_i, .in_ready_o,
    .band_top_i(band_top), .frame_end_i(frame_end), .rows_rcv_o(rows_rcv),
    .rd_slot_i(rd_slot), .rd_col_i(rd_col), .rd_data_o(rd_data)
  );

  dwc_scan #(.SW(SW), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
    .clk_i, .rst_ni, .rows_rcv_i(rows_rcv), .band_top_o(band_top),
    .frame_end_o(frame_end), .rd_slot_o(rd_slot), .rd_col_o(rd_col),
    .rd_data_i(rd_data), .win_valid_o, .win_o(win), .frame_done_o
  );

  assign win_o = win;

  dwc_serializer #(.PW(PW), .GPB(IMG_W / 2)) u_ser (
    .clk_i, .fast_clk_i, .rst_ni, .dec_valid_i,
    .dec_pix_i(dec_pix_i), .pix_valid_o, .pix_o, .underflow_o
  );

  a_r5_done_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> win_valid_o);
  a_r1_win_needs_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ($past(rows_rcv) >= RW'(3)));
endmodule

// File: tb/tb_decode_window_ctrl.sv
`timescale 1ns/1ps
module tb_decode_window_ctrl;
  localparam int W = 16;
  localparam int H = 8;
  localparam int WPF = (W / 2) * (H / 2);

  logic clk = 1'b0, fclk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic in_ready_o, win_valid_o, frame_done_o, pix_valid_o, underflow_o;
  logic [71:0] win_o;
  logic dec_valid = 1'b0;
  logic [31:0] dec_pix = '0;
  logic [7:0] pix_o;

  always #10 clk = ~clk;
  initial begin #1; forever #2.5 fclk = ~fclk; end

  decode_window_ctrl #(.SW(8), .PW(8), .IMG_W(W), .IMG_H(H)) dut (
    .clk_i(clk), .fast_clk_i(fclk), .rst_ni, .in_valid_i(in_valid),
    .in_sample_i(in_sample), .in_ready_o, .win_valid_o, .win_o,
    .frame_done_o, .dec_valid_i(dec_valid), .dec_pix_i(dec_pix),
    .pix_valid_o, .pix_o, .underflow_o
  );

  int tests = 0, fails = 0;
  int cyc = 0, win_cnt = 0, pix_cnt = 0, und_cnt = 0, done_cnt = 0, done_idx = -1;
  logic [71:0] win_log [0:127];
  int stamp [0:127];
  logic [7:0] pix_log [0:511];

  function automatic logic [7:0] smp(int fr, int r, int c);
    return 8'(fr * W * H + r * W + c);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench decoder: top-left 2x2 of each window, optional one-cycle stall
  logic [31:0] q [0:255];
  int qh = 0, qt = 0, stall_at = -1;
  bit stalled = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (win_valid_o) begin
      q[qt] = {win_o[4*8 +: 8], win_o[3*8 +: 8], win_o[1*8 +: 8], win_o[0 +: 8]};
      qt = qt + 1;
    end
    if (qh == stall_at && !stalled) begin
      stalled = 1'b1;
      dec_valid <= 1'b0;
    end else if (qt > qh) begin
      dec_valid <= 1'b1;
      dec_pix   <= q[qh];
      qh = qh + 1;
    end else begin
      dec_valid <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && win_valid_o) begin
      win_log[win_cnt] <= win_o;
      stamp[win_cnt]   <= cyc;
      if (frame_done_o) begin
        done_cnt <= done_cnt + 1;
        done_idx <= win_cnt;
      end
      win_cnt <= win_cnt + 1;
    end
  end

  always @(negedge fclk) begin
    if (rst_ni) begin
      if (pix_valid_o) begin
        pix_log[pix_cnt] <= pix_o;
        pix_cnt <= pix_cnt + 1;
      end
      if (underflow_o) und_cnt <= und_cnt + 1;
    end
  end

  task automatic send(logic [7:0] v);
    in_valid  = 1'b1;
    in_sample = v;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_frame(int fr);
    for (int k = 0; k < WPF; k++) begin
      int g = fr * WPF + k;
      int b = k / (W / 2);
      int c = 2 * (k % (W / 2));
      logic [71:0] exp;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) begin
          int r  = (2*b + i > H - 1) ? H - 1 : 2*b + i;
          int cc = (c + j > W - 1) ? W - 1 : c + j;
          exp[(3*i+j)*8 +: 8] = smp(fr, r, cc);
        end
      chk(win_log[g] == exp, "R2/R4 window content", int'(win_log[g][31:0]), int'(exp[31:0]));
    end
    for (int b = 0; b < H / 2; b++) begin
      int g0 = fr * WPF + b * (W / 2);
      chk(stamp[g0 + W/2 - 1] - stamp[g0] == W/2 - 1, "R2 band on consecutive cycles",
          stamp[g0 + W/2 - 1] - stamp[g0], W/2 - 1);
    end
    for (int p = 0; p < WPF * 4; p++) begin
      int k = p / 4, ln = p % 4;
      int b = k / (W / 2), c = 2 * (k % (W / 2));
      logic [7:0] e = smp(fr, 2*b + ln/2, c + ln%2);
      chk(pix_log[fr * WPF * 4 + p] == e, "R6 serial pixel order",
          int'(pix_log[fr * WPF * 4 + p]), int'(e));
    end
  endtask

  // spot windows {index, element 0, element 8}, right and bottom edges
  localparam int TBL [6][3] = '{
    '{0, 0, 34}, '{7, 14, 47}, '{8, 32, 66},
    '{15, 46, 79}, '{24, 96, 114}, '{31, 110, 127}
  };

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R8 reset ready", in_ready_o, 1);
    chk(win_valid_o == 1'b0, "R8 reset win_valid", win_valid_o, 0);
    chk(frame_done_o == 1'b0, "R8 reset frame_done", frame_done_o, 0);
    chk(pix_valid_o == 1'b0, "R8 reset pix_valid", pix_valid_o, 0);
    chk(underflow_o == 1'b0, "R8 reset underflow", underflow_o, 0);

    for (int s = 0; s < 3 * W - 1; s++) send(smp(0, s / W, s % W));
    repeat (5) @(negedge clk);
    chk(win_cnt == 0, "R1 no window before three rows", win_cnt, 0);
    send(smp(0, 2, W - 1));
    chk(win_valid_o == 1'b0, "R1 window not on accept edge", win_valid_o, 0);
    chk(in_ready_o == 1'b0, "R3 ready low with band rows held", in_ready_o, 0);
    @(negedge clk);
    chk(win_valid_o == 1'b1, "R1 first window one edge later", win_valid_o, 1);
    repeat (W/2 - 2) @(negedge clk);
    chk(in_ready_o == 1'b0, "R3 ready low until last band window", in_ready_o, 0);
    @(negedge clk);
    chk(in_ready_o == 1'b1 && win_valid_o == 1'b1, "R3 ready reopens with last window",
        in_ready_o, 1);

    for (int s = 3 * W; s < W * H; s++) send(smp(0, s / W, s % W));
    while (win_cnt < WPF) @(negedge clk);
    repeat (20) @(negedge clk);

    for (int t = 0; t < 6; t++) begin
      chk(win_log[TBL[t][0]][7:0] == 8'(TBL[t][1]), "R4 spot element 0",
          int'(win_log[TBL[t][0]][7:0]), TBL[t][1]);
      chk(win_log[TBL[t][0]][71:64] == 8'(TBL[t][2]), "R4 spot element 8 edge fill",
          int'(win_log[TBL[t][0]][71:64]), TBL[t][2]);
    end
    check_frame(0);
    chk(done_cnt == 1 && done_idx == WPF - 1, "R5 frame_done with last window",
        done_idx, WPF - 1);
    chk(pix_cnt == WPF * 4, "R6 pixel count", pix_cnt, WPF * 4);
    chk(und_cnt == 0, "R7 no underflow on continuous groups", und_cnt, 0);
    chk(in_ready_o == 1'b1, "R5 next frame accepted", in_ready_o, 1);

    stall_at = WPF + 3;
    for (int s = 0; s < W * H; s++) send(smp(1, s / W, s % W));
    while (win_cnt < 2 * WPF) @(negedge clk);
    repeat (20) @(negedge clk);
    check_frame(1);
    chk(done_cnt == 2 && done_idx == 2 * WPF - 1, "R5 second frame_done",
        done_idx, 2 * WPF - 1);
    chk(und_cnt == 1, "R7 single underflow on mid-band late group", und_cnt, 1);
    chk(pix_cnt == 2 * WPF * 4, "R6 pixel count after stall", pix_cnt, 2 * WPF * 4);

    summary();
    $finish;
  end
endmodule